// File: doc/BRIEF.md
# Time-Aware Transmit Gate Sequencer

This block plays a repeating list of transmit-gate commands for one Ethernet port. Each command word gives an 8-bit mask that says which of the eight transmit priorities may send. It also gives a duration measured in transmit data units. An external pulse marks the start of each schedule cycle. On that pulse the sequencer goes back to the first command of the active bank and drives that command's mask to the transmit scheduler. It counts down the duration on the byte-tick input and then steps to the next command. A command with a zero duration ends the list, and its mask then stays in force until the next pulse.

The command store has two banks of 64 words, written through a simple write port. Software fills the idle bank, then sets the requested-bank input. The active bank changes only at the next cycle-start pulse. Software treats the change as complete once the reported active bank equals its request. A single-bank mode pins the active bank to bank 0. Two sticky flags report faults. One marks a pulse that arrived before the list had ended. The other marks a list that ran past its last slot without reaching a terminator.

The controller has four states. IDLE means not running. LOAD fetches the command at the current index. RUN counts down the command's duration. HOLD waits for the next pulse after a terminator or after running off the end of the list. The transitions are:
- IDLE→LOAD on a pulse while enabled.
- LOAD→RUN when the count is non-zero.
- LOAD→HOLD when the count is zero.
- RUN→LOAD when the count is used up and the index is below 63.
- RUN→HOLD when the count is used up at index 63.
- Any state→LOAD on a pulse while enabled.
- Any state→IDLE when either enable is clear.

Top module: `time_gate_exec`

## Requirements
- R1: A written word stores the allow mask in bits 7:0 and the duration count in bits 21:8. `wr_bank` and `wr_idx` select where it goes. When the sequencer fetches that word, its mask appears on `gate_allow` exactly as stored.
- R2: When `cycle_start` is sampled high while running is enabled, the sequencer moves to command 0 of the active bank. That command's mask drives `gate_allow` after the following clock edge.
- R3: Each sampled `byte_tick` in RUN uses 1 count unit when `link_gig` is 1 and 2 units when it is 0. The command ends on the tick that brings the remaining count to zero or below. The next command's mask appears two edges after that tick.
- R4: A command whose count is zero keeps its mask on `gate_allow` until the next cycle-start pulse. Later ticks have no effect on it.
- R5: A change of `bank_req` changes `active_bank` only at a cycle-start pulse sampled while enabled, and the commands are then read from that bank.
- R6: When `single_bank` is 1, a pulse makes bank 0 active whatever `bank_req` holds.
- R7: When `global_en` or `port_en` is 0, `gate_allow` is 8'hFF and pulses are ignored. After both are set again, the output stays 8'hFF until a pulse starts a cycle.
- R8: A pulse that arrives while a command is being fetched or counted sets `cnt_err`. The flag is sticky until reset, and the sequencer restarts at command 0.
- R9: When the command at index 63 runs out without a zero-count command having been met, `addr_err` is set. The flag is sticky, and that command's mask is held until the next pulse.
- R10: `status` is {addr_err, cnt_err, active_bank, gate_allow}, with the mask in bits 7:0, the active bank in bit 8, `cnt_err` in bit 9 and `addr_err` in bit 10.
- R11: After reset the sequencer is IDLE, `gate_allow` is 8'hFF, `active_bank` is 0 and both flags are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| global_en | input | 1 | Switch-wide schedule enable |
| port_en | input | 1 | Per-port schedule enable |
| bank_req | input | 1 | Bank wanted for the next cycle |
| single_bank | input | 1 | Use bank 0 only |
| link_gig | input | 1 | 1: one unit per tick, 0: two units per tick |
| byte_tick | input | 1 | Transmit-byte tick |
| cycle_start | input | 1 | Schedule cycle pulse |
| wr_en | input | 1 | Command write strobe |
| wr_bank | input | 1 | Bank being written |
| wr_idx | input | 6 | Command index being written |
| wr_data | input | 22 | Command word |
| gate_allow | output | 8 | Per-priority transmit allow |
| active_bank | output | 1 | Bank in use |
| cnt_err | output | 1 | Sticky early-pulse flag |
| addr_err | output | 1 | Sticky list-overrun flag |
| status | output | 11 | Packed status word |

## Verification
A wrong index or a wrong remaining count shows up on `gate_allow` within one command duration: the mask changes a tick early or late, or comes from the wrong slot. A wrong state shows up the same way. A wrong active bank shows on `active_bank` right after the pulse, and the wrong bank's masks follow two edges later. The bench compares every output against a behavioural model on every clock, so any divergence is reported in the cycle it first appears.

// File: rtl/tgs_pkg.sv
package tgs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_RUN,
        ST_HOLD
    } seq_state_t;
endpackage

// File: rtl/tgs_cmd_mem.sv
module tgs_cmd_mem #(
    parameter int DEPTH  = 64,
    parameter int WORD_W = 22,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic              wr_bank,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_bank,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_word
);
    logic [WORD_W-1:0] bank_word [2];

    for (genvar b = 0; b < 2; b++) begin : g_bank
        logic [WORD_W-1:0] slots [DEPTH];
        always_ff @(posedge clk) begin
            if (wr_en && (wr_bank == b[0]))
                slots[wr_idx] <= wr_data;
        end
        assign bank_word[b] = slots[rd_idx];
    end

    assign rd_word = bank_word[rd_bank];
endmodule

// File: rtl/tgs_sequencer.sv
module tgs_sequencer
    import tgs_pkg::*;
#(
    parameter int MASK_W = 8,
    parameter int CNT_W  = 14,
    parameter int DEPTH  = 64,
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int WORD_W = CNT_W + MASK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic              cycle_start,
    input  logic              byte_tick,
    input  logic              link_gig,
    input  logic              bank_req,
    input  logic              single_bank,
    input  logic [WORD_W-1:0] cmd_word,
    output logic              act_bank,
    output logic [IDX_W-1:0]  cmd_idx,
    output logic [MASK_W-1:0] mask_q,
    output logic              running,
    output logic              cnt_err,
    output logic              addr_err
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

    seq_state_t state_q, state_d;
    logic [CNT_W-1:0]  rem_q;
    logic [CNT_W-1:0]  step;
    logic [CNT_W-1:0]  cmd_cnt;
    logic [MASK_W-1:0] cmd_mask;
    logic              cmd_done;

    assign cmd_mask = cmd_word[MASK_W-1:0];
    assign cmd_cnt  = cmd_word[WORD_W-1:MASK_W];
    assign step     = link_gig ? CNT_W'(1) : CNT_W'(2);
    assign cmd_done = byte_tick && (rem_q <= step);
    assign running  = (state_q != ST_IDLE);

    always_comb begin
        state_d = state_q;
        if (!run_en) begin
            state_d = ST_IDLE;
        end else if (cycle_start) begin
            state_d = ST_LOAD;
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_IDLE;
                ST_LOAD: state_d = (cmd_cnt == '0) ? ST_HOLD : ST_RUN;
                ST_RUN: begin
                    if (cmd_done)
                        state_d = (cmd_idx == LAST_IDX) ? ST_HOLD : ST_LOAD;
                end
                ST_HOLD: state_d = ST_HOLD;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_bank <= 1'b0;
            cmd_idx  <= '0;
            mask_q   <= '1;
            rem_q    <= '0;
            cnt_err  <= 1'b0;
            addr_err <= 1'b0;
        end else if (run_en && cycle_start) begin
            if (state_q == ST_LOAD || state_q == ST_RUN)
                cnt_err <= 1'b1;
            act_bank <= single_bank ? 1'b0 : bank_req;
            cmd_idx  <= '0;
        end else if (run_en) begin
            unique case (state_q)
                ST_LOAD: begin
                    mask_q <= cmd_mask;
                    rem_q  <= cmd_cnt;
                end
                ST_RUN: begin
                    if (cmd_done) begin
                        if (cmd_idx == LAST_IDX) addr_err <= 1'b1;
                        else                     cmd_idx  <= cmd_idx + 1'b1;
                    end else if (byte_tick) begin
                        rem_q <= rem_q - step;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/tgs_gate_out.sv
module tgs_gate_out #(
    parameter int MASK_W = 8,
    localparam int STAT_W = MASK_W + 3
) (
    input  logic              run_en,
    input  logic              running,
    input  logic [MASK_W-1:0] mask_q,
    input  logic              act_bank,
    input  logic              cnt_err,
    input  logic              addr_err,
    output logic [MASK_W-1:0] gate_allow,
    output logic [STAT_W-1:0] status
);
    always_comb begin
        gate_allow = (run_en && running) ? mask_q : '1;
        status     = {addr_err, cnt_err, act_bank, gate_allow};
    end
endmodule

// File: rtl/time_gate_exec.sv
module time_gate_exec #(
    parameter int MASK_W = 8,
    parameter int CNT_W  = 14,
    parameter int DEPTH  = 64,
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int WORD_W = CNT_W + MASK_W,
    localparam int STAT_W = MASK_W + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              global_en,
    input  logic              port_en,
    input  logic              bank_req,
    input  logic              single_bank,
    input  logic              link_gig,
    input  logic              byte_tick,
    input  logic              cycle_start,
    input  logic              wr_en,
    input  logic              wr_bank,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_data,
    output logic [MASK_W-1:0] gate_allow,
    output logic              active_bank,
    output logic              cnt_err,
    output logic              addr_err,
    output logic [STAT_W-1:0] status
);
    logic              run_en;
    logic              running;
    logic [IDX_W-1:0]  cmd_idx;
    logic [WORD_W-1:0] cmd_word;
    logic [MASK_W-1:0] mask_q;

    assign run_en = global_en && port_en;

    tgs_cmd_mem #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_mem (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_bank (wr_bank),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .rd_bank (active_bank),
        .rd_idx  (cmd_idx),
        .rd_word (cmd_word)
    );

    tgs_sequencer #(.MASK_W(MASK_W), .CNT_W(CNT_W), .DEPTH(DEPTH)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_en      (run_en),
        .cycle_start (cycle_start),
        .byte_tick   (byte_tick),
        .link_gig    (link_gig),
        .bank_req    (bank_req),
        .single_bank (single_bank),
        .cmd_word    (cmd_word),
        .act_bank    (active_bank),
        .cmd_idx     (cmd_idx),
        .mask_q      (mask_q),
        .running     (running),
        .cnt_err     (cnt_err),
        .addr_err    (addr_err)
    );

    tgs_gate_out #(.MASK_W(MASK_W)) u_out (
        .run_en     (run_en),
        .running    (running),
        .mask_q     (mask_q),
        .act_bank   (active_bank),
        .cnt_err    (cnt_err),
        .addr_err   (addr_err),
        .gate_allow (gate_allow),
        .status     (status)
    );
endmodule

// File: rtl/time_gate_exec_chk.sv
module time_gate_exec_chk #(
    parameter int MASK_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              global_en,
    input logic              port_en,
    input logic              single_bank,
    input logic              cycle_start,
    input logic [MASK_W-1:0] gate_allow,
    input logic              active_bank,
    input logic              cnt_err,
    input logic              addr_err
);
    // R5: the active bank moves only on a pulse
    a_r5_bank_steady: assert property (@(posedge clk) disable iff (!rst_n)
        !cycle_start |=> $stable(active_bank));

    // R6: single-bank mode forces bank 0
    a_r6_single_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cycle_start && global_en && port_en && single_bank) |=> (active_bank == 1'b0));

    // R7: disabled port opens every gate
    a_r7_open_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !(global_en && port_en) |-> (gate_allow == '1));

    // R8: early-pulse flag is sticky and only a pulse raises it
    a_r8_cnt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_err |=> cnt_err);
    a_r8_cnt_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cnt_err) |-> $past(cycle_start));

    // R9: overrun flag is sticky
    a_r9_addr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        addr_err |=> addr_err);
endmodule

bind time_gate_exec time_gate_exec_chk #(.MASK_W(MASK_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .global_en   (global_en),
    .port_en     (port_en),
    .single_bank (single_bank),
    .cycle_start (cycle_start),
    .gate_allow  (gate_allow),
    .active_bank (active_bank),
    .cnt_err     (cnt_err),
    .addr_err    (addr_err)
);

// File: tb/tb_time_gate_exec.sv
module tb_time_gate_exec;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        global_en = 1'b0, port_en = 1'b0, bank_req = 1'b0, single_bank = 1'b0;
    logic        link_gig = 1'b1, byte_tick = 1'b0, cycle_start = 1'b0;
    logic        wr_en = 1'b0, wr_bank = 1'b0;
    logic [5:0]  wr_idx = '0;
    logic [21:0] wr_data = '0;
    logic [7:0]  gate_allow;
    logic        active_bank, cnt_err, addr_err;
    logic [10:0] status;

    int checks = 0, errors = 0, cycles = 0, tick_mode = 0, tick_ph = 0;
    bit done = 0;
    string cur_req = "R2";

    // reference model
    logic [21:0] m_mem [128];
    int m_st, m_idx, m_rem;
    logic [7:0] m_mask;
    bit m_bank, m_ce, m_ae;

    time_gate_exec dut (.*);

    always #10 clk = ~clk;

    task automatic chk(string req, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic int m_gate();
        return (!(global_en && port_en) || m_st == 0) ? 8'hFF : int'(m_mask);
    endfunction

    initial for (int i = 0; i < 128; i++) m_mem[i] = '0;

    always @(posedge clk) begin
        int step;
        logic [21:0] w;
        cycles++;
        if (!rst_n) begin
            m_st = 0; m_idx = 0; m_rem = 0; m_mask = 8'hFF;
            m_bank = 0; m_ce = 0; m_ae = 0;
        end else begin
            step = link_gig ? 1 : 2;
            w = m_mem[{m_bank, 6'(m_idx)}];
            if (!(global_en && port_en)) m_st = 0;
            else if (cycle_start) begin
                if (m_st == 1 || m_st == 2) m_ce = 1;
                m_bank = single_bank ? 1'b0 : bank_req;
                m_idx = 0; m_st = 1;
            end else if (m_st == 1) begin
                m_mask = w[7:0]; m_rem = int'(w[21:8]);
                m_st = (m_rem == 0) ? 3 : 2;
            end else if (m_st == 2 && byte_tick) begin
                if (m_rem <= step) begin
                    if (m_idx == 63) begin m_ae = 1; m_st = 3; end
                    else begin m_idx++; m_st = 1; end
                end else m_rem -= step;
            end
        end
        if (rst_n && wr_en) m_mem[{wr_bank, wr_idx}] = wr_data;
        #5;
        chk(cur_req, int'(gate_allow), m_gate(), "gate_allow");
        chk("R5", int'(active_bank), int'(m_bank), "active_bank");
        chk("R8", int'(cnt_err), int'(m_ce), "cnt_err");
        chk("R9", int'(addr_err), int'(m_ae), "addr_err");
        chk("R10", int'(status), int'({m_ae, m_ce, m_bank, 8'(m_gate())}), "status");
    end

    always @(negedge clk) begin
        tick_ph++;
        byte_tick <= (tick_mode == 1) || (tick_mode == 2 && tick_ph[0]);
    end

    always @(posedge clk) begin
        if (cycles > 100000 && !done) begin
            done = 1; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic wait_clk(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(bit b, int idx, int cnt, int mask);
        @(negedge clk);
        wr_en = 1; wr_bank = b; wr_idx = 6'(idx); wr_data = {14'(cnt), 8'(mask)};
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic pulse();
        @(negedge clk); cycle_start = 1;
        @(negedge clk); cycle_start = 0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 0;
        wait_clk(2); rst_n = 1;
    endtask

    initial begin
        wait_clk(3);
        cur_req = "R11";
        chk("R11", int'(status), 11'h0FF, "status after reset");
        rst_n = 1;
        cur_req = "R1";
        wr(0, 0, 3, 8'h01); wr(0, 1, 4, 8'h02); wr(0, 2, 0, 8'h04);
        wr(1, 0, 2, 8'h10); wr(1, 1, 0, 8'h20);
        global_en = 1; port_en = 1; tick_mode = 1;
        pulse();
        wait_clk(1);
        chk("R1", int'(gate_allow), 8'h01, "first command mask");
        wait_clk(30);
        chk("R4", int'(gate_allow), 8'h04, "terminator mask held");
        cur_req = "R2";
        pulse(); wait_clk(30);
        cur_req = "R3";
        link_gig = 0; tick_mode = 2;
        pulse(); wait_clk(30);
        link_gig = 1; tick_mode = 1;
        cur_req = "R5";
        bank_req = 1; wait_clk(5);
        chk("R5", int'(active_bank), 0, "bank before pulse");
        pulse(); wait_clk(30);
        chk("R5", int'(gate_allow), 8'h20, "new bank terminator");
        chk("R10", int'(status), 11'h120, "packed status");
        cur_req = "R8";
        bank_req = 0; wr(0, 0, 500, 8'h08);
        pulse(); wait_clk(10); pulse(); wait_clk(2);
        chk("R8", int'(cnt_err), 1, "early pulse flag");
        do_reset();
        cur_req = "R9";
        for (int i = 0; i < 64; i++) wr(1, i, 1, i);
        bank_req = 1; pulse(); wait_clk(200);
        chk("R9", int'(addr_err), 1, "overrun flag");
        chk("R9", int'(gate_allow), 8'h3F, "last mask held");
        pulse(); wait_clk(20);
        cur_req = "R6";
        wr(0, 0, 3, 8'h01);
        single_bank = 1; pulse(); wait_clk(40);
        chk("R6", int'(active_bank), 0, "single bank");
        chk("R6", int'(gate_allow), 8'h04, "bank0 terminator");
        cur_req = "R7";
        port_en = 0; wait_clk(3);
        chk("R7", int'(gate_allow), 8'hFF, "port disabled");
        pulse(); port_en = 1; wait_clk(5);
        chk("R7", int'(gate_allow), 8'hFF, "idle until pulse");
        pulse(); wait_clk(40);
        chk("R7", int'(gate_allow), 8'h04, "resumed");
        global_en = 0; wait_clk(3);
        chk("R7", int'(gate_allow), 8'hFF, "global disabled");
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule